// File: doc/BRIEF.md
# Counted-Loop Branch Control Unit

This block resolves branches for a processor pipeline and holds the three pieces of control state they depend on: a loop count register, a return-address (link) register and a bank of condition fields written by compares. An issue stage presents at most one operation per cycle. The operation either loads a register, records a compare result, or asks for a branch decision. For every branch the unit reports whether it is taken and which PC comes next.

Its distinguishing feature is the counted branch. One operation decrements the count register and tests the decremented value, either on its own or ANDed with a chosen condition bit. A loop therefore closes in a single operation, with no separate compare or subtract. Branches can also record their fall-through address in the link register, and a return-style branch jumps through that register.

Results are registered. The outcome of an operation issued on one clock edge appears on the result ports and in the visible register values after that edge.

Top module: `loop_branch_unit`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the count, link and all condition fields read zero and res_valid is low.
- R2: Op code 1 loads issue_src_a into the count register. Op code 2 loads issue_src_a into the link register. Either value is visible on the next cycle.
- R3: The decrementing branches (op codes 6, 7, 8) always write count minus one into the count register. A count of zero wraps to all ones.
- R4: Op code 6 is taken exactly when the decremented count is nonzero. Op code 7 is taken exactly when the decremented count is zero.
- R5: Op code 8 is taken exactly when the decremented count is nonzero and the selected condition bit is 1.
- R6: Op code 3 compares issue_src_a with issue_src_b as signed numbers. It writes field issue_cr_sel as {LT,GT,EQ,SO} in bits 3..0, with SO copied from issue_so. No other field changes. Field k sits at cr_value[4k+3:4k].
- R7: Op code 5 is taken exactly when condition bit issue_cr_bit of field issue_cr_sel (3=LT, 2=GT, 1=EQ, 0=SO) equals issue_expect.
- R8: A branch (op codes 4 to 9) issued with issue_link high writes issue_pc+4 into the link register. A return branch reads the link value from before that write. Non-branch ops ignore issue_link.
- R9: Op code 9 is always taken, and its target is the link register with its two low bits cleared.
- R10: res_valid is high exactly in the cycle after an issue. res_next_pc is the target when taken and issue_pc+4 otherwise.
- R11: Op code 4 is always taken, with target issue_target. Every other branch that uses a direct target also takes issue_target.
- R12: With issue_valid low, or for op code 0, no register changes. Non-branch ops report not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An operation is presented this cycle |
| issue_op | input | 4 | Operation code |
| issue_pc | input | XLEN | PC of the issued operation |
| issue_src_a | input | XLEN | First operand (register load value, compare left side) |
| issue_src_b | input | XLEN | Compare right side |
| issue_target | input | XLEN | Direct branch target |
| issue_link | input | 1 | Save issue_pc+4 into the link register on a branch |
| issue_cr_sel | input | SEL_W | Condition field index |
| issue_cr_bit | input | 2 | Bit within the field |
| issue_expect | input | 1 | Required bit value for op code 5 |
| issue_so | input | 1 | Overflow summary value stored by a compare |
| res_valid | output | 1 | Result of last cycle's operation is present |
| res_taken | output | 1 | Branch taken |
| res_next_pc | output | XLEN | Next PC |
| ctr_value | output | XLEN | Count register |
| lr_value | output | XLEN | Link register |
| cr_value | output | 4*NFIELD | All condition fields |

## Verification
The assertions assume the issue stage presents one well-formed operation per cycle. Op codes outside 0 to 9 behave as no-ops, and issue_cr_sel always names an existing field. They also assume that issue_link matters only together with a branch code, which is how the checks on the link register are phrased. The scoreboard driver sends only codes from the defined list and keeps field indices below NFIELD. It mixes back-to-back issues with idle cycles, so that the one-cycle result timing is tested under both conditions.

// File: rtl/bru_pkg.sv
// Package: shared operation codes and classification helpers for the
// counted-loop branch unit. Assumes a 4-bit operation code.
package bru_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_LDCTR = 4'd1,
        OP_LDLR  = 4'd2,
        OP_CMP   = 4'd3,
        OP_JMP   = 4'd4,
        OP_JCOND = 4'd5,
        OP_LOOPNZ = 4'd6,
        OP_LOOPZ = 4'd7,
        OP_LOOPNZC = 4'd8,
        OP_RET   = 4'd9
    } bru_op_e;

    localparam int unsigned FIELD_W = 4;

    // True for any operation that resolves a branch.
    function automatic logic is_branch(input bru_op_e op);
        return (op == OP_JMP) || (op == OP_JCOND) || (op == OP_LOOPNZ) ||
               (op == OP_LOOPZ) || (op == OP_LOOPNZC) || (op == OP_RET);
    endfunction

    // True for operations that decrement the count register.
    function automatic logic uses_count(input bru_op_e op);
        return (op == OP_LOOPNZ) || (op == OP_LOOPZ) || (op == OP_LOOPNZC);
    endfunction

endpackage

// File: rtl/bru_count_reg.sv
// Count register: loads a value or decrements by one, wrapping from zero to
// all ones. Assumes load and decrement are never requested together.
module bru_count_reg #(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [XLEN-1:0] load_val,
    input  logic            dec_en,
    output logic [XLEN-1:0] count_q,
    output logic [XLEN-1:0] count_dec
);

    // Decremented value, used both for the update and for the branch test.
    assign count_dec = count_q - XLEN'(1);

    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (load_en) count_q <= load_val;
        else if (dec_en)  count_q <= count_dec;
    end

    assert_count_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |=> count_q == $past(count_q) - XLEN'(1));

    assert_count_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> count_q == $past(load_val));

    assert_count_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !dec_en) |=> $stable(count_q));

endmodule

// File: rtl/bru_link_reg.sv
// Link register: loaded from an operand or from the fall-through PC of a
// linking branch. Assumes the two write requests are mutually exclusive.
module bru_link_reg #(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [XLEN-1:0] load_val,
    input  logic            link_en,
    input  logic [XLEN-1:0] link_val,
    output logic [XLEN-1:0] link_q
);

    // Link register update; a linking branch wins over a plain load.
    always_ff @(posedge clk) begin
        if (!rst_n)       link_q <= '0;
        else if (link_en) link_q <= link_val;
        else if (load_en) link_q <= load_val;
    end

    assert_link_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        link_en |=> link_q == $past(link_val));

    assert_link_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_en && !load_en) |=> $stable(link_q));

endmodule

// File: rtl/bru_cond_bank.sv
// Condition field bank: NFIELD fields of {LT,GT,EQ,SO}. A compare writes one
// field; a single bit of any field can be read combinationally.
// Assumes wr_sel and rd_sel always index an existing field.
module bru_cond_bank #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned NFIELD = 8,
    localparam int unsigned SEL_W = (NFIELD > 1) ? $clog2(NFIELD) : 1,
    localparam int unsigned FW    = bru_pkg::FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [XLEN-1:0]   lhs,
    input  logic [XLEN-1:0]   rhs,
    input  logic              so_in,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic [1:0]        rd_bit,
    output logic              rd_val,
    output logic [NFIELD*FW-1:0] bank_flat
);

    logic [FW-1:0] fields [NFIELD];
    logic [FW-1:0] new_field;

    // Signed three-way comparison packed as {LT,GT,EQ,SO}.
    always_comb begin
        new_field[3] = $signed(lhs) <  $signed(rhs);
        new_field[2] = $signed(lhs) >  $signed(rhs);
        new_field[1] = lhs == rhs;
        new_field[0] = so_in;
    end

    for (genvar k = 0; k < NFIELD; k++) begin : g_field
        // Field storage: written only when this field is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                fields[k] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(k)))
                fields[k] <= new_field;
        end

        assign bank_flat[k*FW +: FW] = fields[k];

        assert_other_field_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_sel == SEL_W'(k))) |=> $stable(fields[k]));
    end

    // Single-bit read port for conditional branches.
    assign rd_val = fields[rd_sel][rd_bit];

    assert_cmp_one_relation_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $countones(fields[$past(wr_sel)][3:1]) == 1);

endmodule

// File: rtl/bru_decide.sv
// Branch decision: from the operation, the decremented count, the selected
// condition bit and the link register, forms taken, next PC and the count
// decrement request. Purely combinational; gated by issue valid in the top.
module bru_decide
    import bru_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  bru_op_e         op,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] target,
    input  logic [XLEN-1:0] count_dec,
    input  logic [XLEN-1:0] link_q,
    input  logic            cond_bit,
    input  logic            expect_val,
    output logic            taken,
    output logic            dec_req,
    output logic [XLEN-1:0] next_pc
);

    logic            count_nz;
    logic [XLEN-1:0] chosen;

    assign count_nz = |count_dec;

    // Taken decision and target selection per operation.
    always_comb begin
        taken   = 1'b0;
        dec_req = uses_count(op);
        chosen  = target;
        case (op)
            OP_JMP:     taken = 1'b1;
            OP_JCOND:   taken = (cond_bit == expect_val);
            OP_LOOPNZ:  taken = count_nz;
            OP_LOOPZ:   taken = !count_nz;
            OP_LOOPNZC: taken = count_nz && cond_bit;
            OP_RET: begin
                taken  = 1'b1;
                chosen = {link_q[XLEN-1:2], 2'b00};
            end
            default:    taken = 1'b0;
        endcase
        next_pc = taken ? chosen : pc + XLEN'(4);
    end

endmodule

// File: rtl/loop_branch_unit.sv
// Top: counted-loop branch control unit. Accepts one operation per cycle,
// updates count, link and condition state, and registers the branch result
// one cycle after issue. Assumes issue_cr_sel < NFIELD.
module loop_branch_unit
    import bru_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned NFIELD = 8,
    localparam int unsigned SEL_W = (NFIELD > 1) ? $clog2(NFIELD) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   issue_valid,
    input  logic [3:0]             issue_op,
    input  logic [XLEN-1:0]        issue_pc,
    input  logic [XLEN-1:0]        issue_src_a,
    input  logic [XLEN-1:0]        issue_src_b,
    input  logic [XLEN-1:0]        issue_target,
    input  logic                   issue_link,
    input  logic [SEL_W-1:0]       issue_cr_sel,
    input  logic [1:0]             issue_cr_bit,
    input  logic                   issue_expect,
    input  logic                   issue_so,
    output logic                   res_valid,
    output logic                   res_taken,
    output logic [XLEN-1:0]        res_next_pc,
    output logic [XLEN-1:0]        ctr_value,
    output logic [XLEN-1:0]        lr_value,
    output logic [NFIELD*FIELD_W-1:0] cr_value
);

    bru_op_e         op;
    logic [XLEN-1:0] count_dec;
    logic            cond_bit;
    logic            d_taken;
    logic            d_dec;
    logic [XLEN-1:0] d_next_pc;
    logic            ld_ctr_en, ld_lr_en, link_en, cmp_en, dec_en;

    assign op        = bru_op_e'(issue_op);
    assign ld_ctr_en = issue_valid && (op == OP_LDCTR);
    assign ld_lr_en  = issue_valid && (op == OP_LDLR);
    assign cmp_en    = issue_valid && (op == OP_CMP);
    assign link_en   = issue_valid && issue_link && is_branch(op);
    assign dec_en    = issue_valid && d_dec;

    bru_count_reg #(.XLEN(XLEN)) u_count (
        .clk(clk), .rst_n(rst_n),
        .load_en(ld_ctr_en), .load_val(issue_src_a),
        .dec_en(dec_en),
        .count_q(ctr_value), .count_dec(count_dec)
    );

    bru_link_reg #(.XLEN(XLEN)) u_link (
        .clk(clk), .rst_n(rst_n),
        .load_en(ld_lr_en), .load_val(issue_src_a),
        .link_en(link_en), .link_val(issue_pc + XLEN'(4)),
        .link_q(lr_value)
    );

    bru_cond_bank #(.XLEN(XLEN), .NFIELD(NFIELD)) u_cond (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cmp_en), .wr_sel(issue_cr_sel),
        .lhs(issue_src_a), .rhs(issue_src_b), .so_in(issue_so),
        .rd_sel(issue_cr_sel), .rd_bit(issue_cr_bit),
        .rd_val(cond_bit), .bank_flat(cr_value)
    );

    bru_decide #(.XLEN(XLEN)) u_decide (
        .op(op), .pc(issue_pc), .target(issue_target),
        .count_dec(count_dec), .link_q(lr_value),
        .cond_bit(cond_bit), .expect_val(issue_expect),
        .taken(d_taken), .dec_req(d_dec), .next_pc(d_next_pc)
    );

    // Result register: one-cycle pulse per issued operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_taken   <= 1'b0;
            res_next_pc <= '0;
        end else begin
            res_valid <= issue_valid;
            res_taken <= issue_valid && d_taken;
            if (issue_valid) res_next_pc <= d_next_pc;
        end
    end

    assert_result_follows_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> res_valid);

    assert_no_spurious_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> !res_valid);

    assert_jump_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && op == OP_JMP) |=> res_taken && res_next_pc == $past(issue_target));

    assert_ret_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && op == OP_RET) |=>
            res_taken && res_next_pc == {$past(lr_value[XLEN-1:2]), 2'b00});

    assert_link_pc4_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_link && is_branch(op)) |=> lr_value == $past(issue_pc) + XLEN'(4));

    assert_loopnz_test_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && op == OP_LOOPNZ) |=> res_taken == (ctr_value != '0));

    assert_loopz_test_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && op == OP_LOOPZ) |=> res_taken == (ctr_value == '0));

    assert_nonbranch_not_taken_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !is_branch(op)) |=> !res_taken);

endmodule

// File: tb/loop_branch_unit_tb_top.sv
// Scoreboard bench: the driver models expected results and queues them; the
// monitor pops and compares on each result pulse.
module loop_branch_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    localparam logic [3:0] C_NOP = 0, C_LDCTR = 1, C_LDLR = 2, C_CMP = 3, C_JMP = 4,
                           C_JCOND = 5, C_LNZ = 6, C_LZ = 7, C_LNZC = 8, C_RET = 9;

    typedef struct {
        logic        taken;
        logic [31:0] npc;
        logic [31:0] ctr;
        logic [31:0] lr;
        logic [31:0] cr;
        string       tag;
    } exp_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        issue_valid = 0;
    logic [3:0]  issue_op = 0;
    logic [31:0] issue_pc = 0, issue_src_a = 0, issue_src_b = 0, issue_target = 0;
    logic        issue_link = 0;
    logic [2:0]  issue_cr_sel = 0;
    logic [1:0]  issue_cr_bit = 0;
    logic        issue_expect = 0, issue_so = 0;
    logic        res_valid, res_taken;
    logic [31:0] res_next_pc, ctr_value, lr_value, cr_value;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t sb[$];
    logic [31:0] m_ctr = 0, m_lr = 0, m_cr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    loop_branch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_pc(issue_pc), .issue_src_a(issue_src_a), .issue_src_b(issue_src_b),
        .issue_target(issue_target), .issue_link(issue_link),
        .issue_cr_sel(issue_cr_sel), .issue_cr_bit(issue_cr_bit),
        .issue_expect(issue_expect), .issue_so(issue_so),
        .res_valid(res_valid), .res_taken(res_taken), .res_next_pc(res_next_pc),
        .ctr_value(ctr_value), .lr_value(lr_value), .cr_value(cr_value)
    );

    // Driver: present one operation and queue its modelled outcome.
    task automatic issue(input logic [3:0] op, input logic [31:0] pc, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] tgt, input logic lnk,
                         input logic [2:0] sel, input logic [1:0] bsel,
                         input logic expv, input logic so, input string tag);
        exp_t e;
        logic [31:0] nctr, t;
        logic bitv, tk, br;
        bitv = m_cr[sel*4 + bsel];
        nctr = m_ctr - 1;
        t = tgt;
        tk = 0;
        br = (op >= C_JMP) && (op <= C_RET);
        case (op)
            C_JMP:   tk = 1;
            C_JCOND: tk = (bitv == expv);
            C_LNZ:   tk = (nctr != 0);
            C_LZ:    tk = (nctr == 0);
            C_LNZC:  tk = (nctr != 0) && bitv;
            C_RET:   begin tk = 1; t = {m_lr[31:2], 2'b00}; end
            default: tk = 0;
        endcase
        if (op == C_LDCTR) m_ctr = a;
        if (op == C_LNZ || op == C_LZ || op == C_LNZC) m_ctr = nctr;
        if (op == C_LDLR) m_lr = a;
        if (br && lnk) m_lr = pc + 4;
        if (op == C_CMP)
            m_cr[sel*4 +: 4] = {$signed(a) < $signed(b), $signed(a) > $signed(b), a == b, so};
        e.taken = tk;
        e.npc = tk ? t : pc + 4;
        e.ctr = m_ctr; e.lr = m_lr; e.cr = m_cr; e.tag = tag;
        @(negedge clk);
        issue_valid = 1; issue_op = op; issue_pc = pc; issue_src_a = a; issue_src_b = b;
        issue_target = tgt; issue_link = lnk; issue_cr_sel = sel; issue_cr_bit = bsel;
        issue_expect = expv; issue_so = so;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            issue_valid = 0;
        end
    endtask

    task automatic check_state(input string tag);
        checks++;
        if (ctr_value !== m_ctr || lr_value !== m_lr || cr_value !== m_cr || res_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s ctr=%h/%h lr=%h/%h cr=%h/%h vld=%b/0", tag, ctr_value, m_ctr,
                     lr_value, m_lr, cr_value, m_cr, res_valid);
        end
    endtask

    // Monitor: compare each result pulse against the oldest queued item.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected result pulse act=1 exp=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (res_taken !== e.taken || res_next_pc !== e.npc || ctr_value !== e.ctr ||
                    lr_value !== e.lr || cr_value !== e.cr) begin
                    errors++;
                    $display("FAIL %s taken=%b/%b npc=%h/%h ctr=%h/%h lr=%h/%h cr=%h/%h", e.tag,
                             res_taken, e.taken, res_next_pc, e.npc, ctr_value, e.ctr,
                             lr_value, e.lr, cr_value, e.cr);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_state("R1 reset state");

        issue(C_LDCTR, 32'h10, 32'd5, 0, 0, 0, 0, 0, 0, 0, "R2 load count");
        issue(C_LDLR, 32'h14, 32'h1003, 0, 0, 0, 0, 0, 0, 0, "R2 load link");
        idle(2);
        issue(C_RET, 32'h100, 0, 0, 32'hDEAD, 0, 0, 0, 0, 0, "R9 return aligned");
        issue(C_RET, 32'h200, 0, 0, 0, 1, 0, 0, 0, 0, "R8 return with link uses old link");
        issue(C_JMP, 32'h300, 0, 0, 32'h400, 1, 0, 0, 0, 0, "R11 R8 jump and link");
        for (int i = 0; i < 5; i++)
            issue(C_LNZ, 32'h500, 0, 0, 32'h4F0, 0, 0, 0, 0, 0, "R4 R3 loop nonzero");
        idle(1);
        issue(C_LZ, 32'h600, 0, 0, 32'h700, 0, 0, 0, 0, 0, "R3 wrap from zero");
        issue(C_LDCTR, 32'h604, 32'd1, 0, 0, 0, 0, 0, 0, 0, "R2 reload count");
        issue(C_LZ, 32'h608, 0, 0, 32'h800, 0, 0, 0, 0, 0, "R4 loop zero taken");
        issue(C_CMP, 32'h60C, 32'hFFFF_FFFD, 32'd2, 0, 1, 2, 0, 0, 1, "R6 R8 compare lt so");
        issue(C_CMP, 32'h610, 32'd7, 32'd7, 0, 0, 5, 0, 0, 0, "R6 compare eq");
        issue(C_CMP, 32'h614, 32'd9, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, "R6 compare gt");
        issue(C_JCOND, 32'h618, 0, 0, 32'h900, 0, 2, 3, 1, 0, "R7 cond lt expect 1");
        issue(C_JCOND, 32'h61C, 0, 0, 32'h900, 0, 2, 3, 0, 0, "R7 cond lt expect 0");
        issue(C_JCOND, 32'h620, 0, 0, 32'h940, 0, 5, 1, 0, 0, "R7 cond eq expect 0");
        issue(C_JCOND, 32'h624, 0, 0, 32'h980, 0, 2, 0, 1, 0, "R7 cond so expect 1");
        issue(C_LDCTR, 32'h628, 32'd3, 0, 0, 0, 0, 0, 0, 0, "R2 count for combined");
        issue(C_LNZC, 32'h62C, 0, 0, 32'hA00, 0, 2, 3, 0, 0, "R5 combined taken");
        issue(C_LNZC, 32'h630, 0, 0, 32'hA00, 0, 0, 3, 0, 0, "R5 combined bit clear");
        issue(C_LNZC, 32'h634, 0, 0, 32'hA00, 0, 2, 3, 0, 0, "R5 combined count zero");
        issue(C_NOP, 32'h638, 32'h55, 0, 0, 1, 0, 0, 0, 0, "R12 nop");
        issue(C_CMP, 32'h63C, 32'd1, 32'd2, 0, 1, 7, 0, 0, 0, "R8 R12 link ignored on compare");
        idle(2);
        // Operations presented with issue_valid low must not touch any state.
        @(negedge clk);
        issue_op = C_LDCTR; issue_src_a = 32'h77; issue_valid = 0;
        @(negedge clk);
        issue_op = C_CMP; issue_cr_sel = 1; issue_valid = 0;
        @(negedge clk);
        issue_op = C_JMP; issue_link = 1; issue_valid = 0;
        @(negedge clk);
        check_state("R12 invalid issue ignored");
        idle(2);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R10 pending results act=%0d exp=0", sb.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule